// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block turns maskable and non-maskable interrupt requests into a service-routine target for the instruction sequencer. Both request pins are active low and may change at any time relative to the clock. Each pin passes through a synchronizer before any logic uses it. A maskable request is taken only at an instruction boundary, and only while the enable flag is set. Taking it runs an acknowledge cycle, and the interrupting device places a vector byte on the data bus during that cycle.

The vector byte is used in one of three ways, chosen by the mode input:
- The byte can be handed on for execution.
- It can be replaced by a fixed restart address.
- It can become the low half of a pointer whose high half comes from the page register. Two memory reads through that pointer fetch a 16-bit service address, and the block issues it as an indirect call target.

A falling edge on the non-maskable pin is latched. It wins over a maskable request and yields a fixed target without any acknowledge cycle.

Three interfaces are valid/ready streams:
- **Memory read request:** `mem_rd_valid`, `mem_rd_addr`, `mem_rd_ready`.
- **Incoming data bus:** `dbus_valid`, `dbus_data`, `dbus_ready`.
- **Call request:** `call_valid`, `call_*`, `call_ready`.

A transfer happens on a rising edge where valid and ready are both high. Once the block raises a valid, it keeps that valid and its payload unchanged until ready is seen, so the consumer may stall for as long as it likes. The block raises `dbus_ready` only in the states where it waits for a byte, and it ignores `dbus_valid` at all other times.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `ack_m1`, `ack_iorq`, `mem_rd_valid`, `call_valid` and `ie_o` are all 0 until a request is taken.
- R2: A low level on `int_n` starts an acknowledge cycle only if three conditions hold together: the block is idle, `ie_o` is 1, and `insn_end` is 1. If `ie_o` is 0 or `insn_end` is 0, the request is held off with no acknowledge.
- R3: Taking a maskable request clears `ie_o` on the same edge that raises `ack_m1`.
- R4: In the acknowledge cycle, `ack_m1` is high alone for one cycle before `ack_iorq` rises. `ack_iorq` is only ever high together with `ack_m1`. The vector byte is accepted only while both are high, and a byte offered while `ack_m1` is high alone is ignored.
- R5: In table mode (`mode` = 2 or 3), the pointer is {`i_reg`, vector}. The low byte of the target is read from that pointer, and the high byte from the pointer plus one, with the carry going into the upper byte. The call target is {high, low} with `call_exec` = 0.
- R6: In restart mode (`mode` = 1), the call target is the parameter `RST_TARGET` (default 16'h0038), with `call_exec` = 0 and no memory read.
- R7: In execute mode (`mode` = 0), the call request carries `call_exec` = 1, the vector in `call_byte`, and `call_addr` = 0, with no memory read.
- R8: A falling edge on `nmi_n` is latched. At the next boundary it produces a call to `NMI_TARGET` (default 16'h0066), ahead of any pending maskable request. It runs no acknowledge cycle and leaves `ie_o` unchanged. Holding `nmi_n` low does not retrigger it.
- R9: `mem_rd_valid` with `mem_rd_addr`, and `call_valid` with `call_addr`, `call_exec` and `call_byte`, all stay unchanged from the moment valid rises until the handshake.
- R10: A one-cycle pulse on `ie_set` sets `ie_o` to 1. If `ie_set` and acceptance happen in the same cycle, acceptance wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_n | input | 1 | Maskable request, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable request, active low, asynchronous |
| insn_end | input | 1 | High in cycles where an instruction boundary is reached |
| ie_set | input | 1 | Pulse that sets the enable flag |
| ie_o | output | 1 | Enable flag |
| mode | input | 2 | 0 execute byte, 1 restart, 2 or 3 table |
| i_reg | input | 8 | Table page (upper pointer byte) |
| ack_m1 | output | 1 | Acknowledge phase one |
| ack_iorq | output | 1 | Acknowledge phase two, vector strobe |
| dbus_data | input | 8 | Data bus byte |
| dbus_valid | input | 1 | Data bus byte present |
| dbus_ready | output | 1 | Block takes a data bus byte |
| mem_rd_addr | output | 16 | Table read address |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Read request accepted |
| call_addr | output | 16 | Service target address |
| call_exec | output | 1 | Execute `call_byte` instead of calling |
| call_byte | output | 8 | Vector byte captured in acknowledge |
| call_valid | output | 1 | Call request |
| call_ready | input | 1 | Call request accepted |

## Verification
The assertions take the following for granted about the block's inputs:
- The memory and the call consumer raise ready only when they will complete a transfer.
- A byte offered on the data bus counts only on an edge where `dbus_ready` is high.
- `ie_set` is never pulsed while an acknowledge is in progress.

The stimulus keeps within these limits by answering `dbus_ready` with `dbus_valid` on the next edge and by holding each ready low for one cycle before raising it. It deliberately offers a corrupted byte during the cycle where `ack_m1` is high alone. It pulses `ie_set` only while the block is idle.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ACK_M1,
    SQ_ACK_IO,
    SQ_RD_LO,
    SQ_WT_LO,
    SQ_RD_HI,
    SQ_WT_HI,
    SQ_CALL
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_EXEC      = 2'd0,
    MODE_RESTART   = 2'd1,
    MODE_TABLE     = 2'd2,
    MODE_TABLE_ALT = 2'd3
  } resp_mode_t;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int                  VEC_W      = 8,
  parameter logic [2*VEC_W-1:0]  NMI_TARGET = 16'h0066,
  parameter logic [2*VEC_W-1:0]  RST_TARGET = 16'h0038
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               int_act,
  input  logic               nmi_pend,
  input  logic               ie,
  input  logic               insn_end,
  input  logic [1:0]         mode,
  input  logic [VEC_W-1:0]   i_reg,
  output logic               take_int,
  output logic               take_nmi,
  output logic               ack_m1,
  output logic               ack_iorq,
  input  logic [VEC_W-1:0]   dbus_data,
  input  logic               dbus_valid,
  output logic               dbus_ready,
  output logic [2*VEC_W-1:0] mem_rd_addr,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [2*VEC_W-1:0] call_addr,
  output logic               call_exec,
  output logic [VEC_W-1:0]   call_byte,
  output logic               call_valid,
  input  logic               call_ready
);

  localparam int AW = 2 * VEC_W;

  seq_state_t       st;
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] lo_q;
  logic [AW-1:0]    ptr_q;
  logic [AW-1:0]    tgt_q;
  logic             exec_q;
  resp_mode_t       mode_e;
  logic             d_fire;

  assign mode_e   = resp_mode_t'(mode);
  assign take_nmi = (st == SQ_IDLE) && insn_end && nmi_pend;
  assign take_int = (st == SQ_IDLE) && insn_end && !nmi_pend && int_act && ie;
  assign d_fire   = dbus_valid && dbus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      vec_q  <= '0;
      lo_q   <= '0;
      ptr_q  <= '0;
      tgt_q  <= '0;
      exec_q <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (take_nmi) begin
            tgt_q  <= NMI_TARGET;
            exec_q <= 1'b0;
            st     <= SQ_CALL;
          end else if (take_int) begin
            st <= SQ_ACK_M1;
          end
        end
        SQ_ACK_M1: st <= SQ_ACK_IO;
        SQ_ACK_IO: begin
          if (d_fire) begin
            vec_q <= dbus_data;
            unique case (mode_e)
              MODE_EXEC: begin
                tgt_q  <= '0;
                exec_q <= 1'b1;
                st     <= SQ_CALL;
              end
              MODE_RESTART: begin
                tgt_q  <= RST_TARGET;
                exec_q <= 1'b0;
                st     <= SQ_CALL;
              end
              default: begin
                ptr_q <= {i_reg, dbus_data};
                st    <= SQ_RD_LO;
              end
            endcase
          end
        end
        SQ_RD_LO: if (mem_rd_ready) st <= SQ_WT_LO;
        SQ_WT_LO: begin
          if (d_fire) begin
            lo_q  <= dbus_data;
            ptr_q <= ptr_q + AW'(1);
            st    <= SQ_RD_HI;
          end
        end
        SQ_RD_HI: if (mem_rd_ready) st <= SQ_WT_HI;
        SQ_WT_HI: begin
          if (d_fire) begin
            tgt_q  <= {dbus_data, lo_q};
            exec_q <= 1'b0;
            st     <= SQ_CALL;
          end
        end
        SQ_CALL: if (call_ready) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign ack_m1       = (st == SQ_ACK_M1) || (st == SQ_ACK_IO);
  assign ack_iorq     = (st == SQ_ACK_IO);
  assign dbus_ready   = (st == SQ_ACK_IO) || (st == SQ_WT_LO) || (st == SQ_WT_HI);
  assign mem_rd_valid = (st == SQ_RD_LO) || (st == SQ_RD_HI);
  assign mem_rd_addr  = ptr_q;
  assign call_valid   = (st == SQ_CALL);
  assign call_addr    = tgt_q;
  assign call_exec    = exec_q;
  assign call_byte    = vec_q;

  // R4: phase two is always preceded by phase one
  a_r4_iorq_after_m1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_iorq) |-> $past(ack_m1) && !$past(ack_iorq));
  // R4: phase two never stands alone
  a_r4_iorq_with_m1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_iorq |-> ack_m1);
  // R5: second table read is one above the first
  a_r5_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && $past(st == SQ_WT_LO && d_fire)) |->
      mem_rd_addr == $past(mem_rd_addr) + AW'(1));
  // R9: read request held until accepted
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));
  // R9: call request held until accepted
  a_r9_call_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && !call_ready) |=> call_valid && $stable(call_addr) &&
      $stable(call_exec) && $stable(call_byte));

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int                  VEC_W       = 8,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [2*VEC_W-1:0]  NMI_TARGET  = 16'h0066,
  parameter logic [2*VEC_W-1:0]  RST_TARGET  = 16'h0038
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               int_n,
  input  logic               nmi_n,
  input  logic               insn_end,
  input  logic               ie_set,
  output logic               ie_o,
  input  logic [1:0]         mode,
  input  logic [VEC_W-1:0]   i_reg,
  output logic               ack_m1,
  output logic               ack_iorq,
  input  logic [VEC_W-1:0]   dbus_data,
  input  logic               dbus_valid,
  output logic               dbus_ready,
  output logic [2*VEC_W-1:0] mem_rd_addr,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [2*VEC_W-1:0] call_addr,
  output logic               call_exec,
  output logic [VEC_W-1:0]   call_byte,
  output logic               call_valid,
  input  logic               call_ready
);

  logic [1:0] pins_s;
  logic       int_s_n, nmi_s_n, nmi_prev_n;
  logic       nmi_pend, take_int, take_nmi, ie_q;

  irq_pin_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({nmi_n, int_n}),
    .q    (pins_s)
  );

  assign int_s_n = pins_s[0];
  assign nmi_s_n = pins_s[1];

  // edge latch for the non-maskable request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_n <= 1'b1;
      nmi_pend   <= 1'b0;
    end else begin
      nmi_prev_n <= nmi_s_n;
      if (nmi_prev_n && !nmi_s_n) nmi_pend <= 1'b1;
      else if (take_nmi)          nmi_pend <= 1'b0;
    end
  end

  // enable flag: acceptance beats a simultaneous set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ie_q <= 1'b0;
    else if (take_int) ie_q <= 1'b0;
    else if (ie_set)   ie_q <= 1'b1;
  end

  assign ie_o = ie_q;

  irq_ack_seq #(
    .VEC_W     (VEC_W),
    .NMI_TARGET(NMI_TARGET),
    .RST_TARGET(RST_TARGET)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_act     (!int_s_n),
    .nmi_pend    (nmi_pend),
    .ie          (ie_q),
    .insn_end    (insn_end),
    .mode        (mode),
    .i_reg       (i_reg),
    .take_int    (take_int),
    .take_nmi    (take_nmi),
    .ack_m1      (ack_m1),
    .ack_iorq    (ack_iorq),
    .dbus_data   (dbus_data),
    .dbus_valid  (dbus_valid),
    .dbus_ready  (dbus_ready),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready),
    .call_addr   (call_addr),
    .call_exec   (call_exec),
    .call_byte   (call_byte),
    .call_valid  (call_valid),
    .call_ready  (call_ready)
  );

  // R3: the flag is already clear when phase one begins
  a_r3_ie_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_m1) |-> !ie_o);
  // R2: an acknowledge only starts from an enabled flag
  a_r2_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_m1) |-> $past(ie_o));
  // R8: a non-maskable call never follows an acknowledge phase directly
  a_r8_nmi_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && call_addr == NMI_TARGET && !call_exec && $rose(call_valid)) |->
      (!$past(ack_m1) || mode != 2'd1));

endmodule

// File: tb/irq_ack_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ack_ctrl_tb_top;

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  ireg;
    logic [7:0]  vec;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [15:0] exp_addr;
    logic        exp_exec;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'h12, 8'h40, 8'h34, 8'h56, 16'h5634, 1'b0},
    '{2'd2, 8'h7F, 8'hFF, 8'hAA, 8'h55, 16'h55AA, 1'b0},
    '{2'd1, 8'h00, 8'hC7, 8'h00, 8'h00, 16'h0038, 1'b0},
    '{2'd0, 8'h00, 8'hCF, 8'h00, 8'h00, 16'h0000, 1'b1},
    '{2'd3, 8'h00, 8'h00, 8'h01, 8'h80, 16'h8001, 1'b0},
    '{2'd0, 8'h33, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b1},
    '{2'd1, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0038, 1'b0},
    '{2'd2, 8'hFE, 8'h02, 8'hEF, 8'hBE, 16'hBEEF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_n = 1'b1, nmi_n = 1'b1, insn_end = 1'b0, ie_set = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] i_reg = 8'h00, dbus_data = 8'h00;
  logic dbus_valid = 1'b0, mem_rd_ready = 1'b0, call_ready = 1'b0;
  logic ie_o, ack_m1, ack_iorq, dbus_ready, mem_rd_valid, call_exec, call_valid;
  logic [15:0] mem_rd_addr, call_addr;
  logic [7:0] call_byte;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_ack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n),
    .insn_end(insn_end), .ie_set(ie_set), .ie_o(ie_o), .mode(mode),
    .i_reg(i_reg), .ack_m1(ack_m1), .ack_iorq(ack_iorq),
    .dbus_data(dbus_data), .dbus_valid(dbus_valid), .dbus_ready(dbus_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .call_addr(call_addr), .call_exec(call_exec),
    .call_byte(call_byte), .call_valid(call_valid), .call_ready(call_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_ie();
    @(negedge clk); ie_set = 1'b1;
    @(negedge clk); ie_set = 1'b0;
    check(ie_o == 1'b1, "R10", "ie after set", int'(ie_o), 1);
  endtask

  task automatic run_int(input vec_t v);
    bit done = 0, m1_alone = 0, prev_m1 = 0, rd_stall = 0, c_stall = 0;
    int rd_n = 0;
    logic [15:0] rd_seen = '0, last_rd = '0, c_seen = '0;
    logic [15:0] ptr = {v.ireg, v.vec};
    mode = v.mode; i_reg = v.ireg; insn_end = 1'b1; int_n = 1'b0;
    for (int cyc = 0; cyc < 300 && !done; cyc++) begin
      @(negedge clk);
      if (ack_iorq && !prev_m1) check(0, "R4", "iorq without prior m1", 1, 0);
      if (ack_iorq && !m1_alone) check(0, "R4", "iorq before lone m1", 1, 0);
      if (ack_m1 && !ack_iorq) m1_alone = 1;
      prev_m1 = ack_m1;
      if (ack_m1) int_n = 1'b1;
      // offer a corrupted byte while m1 is alone: must be ignored (R4)
      if (ack_m1 && !ack_iorq) begin
        dbus_valid = 1'b1; dbus_data = ~v.vec;
      end else begin
        dbus_valid = dbus_ready;
        dbus_data  = ack_iorq ? v.vec : ((last_rd == ptr) ? v.lo : v.hi);
      end
      if (mem_rd_valid) begin
        if (!rd_stall) begin
          rd_stall = 1; rd_seen = mem_rd_addr; mem_rd_ready = 1'b0;
        end else begin
          check(mem_rd_addr == rd_seen, "R9", "rd addr held", int'(mem_rd_addr), int'(rd_seen));
          check(mem_rd_addr == ((rd_n == 0) ? ptr : ptr + 16'd1), "R5", "table rd addr",
                int'(mem_rd_addr), int'((rd_n == 0) ? ptr : ptr + 16'd1));
          last_rd = mem_rd_addr; rd_n++; rd_stall = 0; mem_rd_ready = 1'b1;
        end
      end else mem_rd_ready = 1'b0;
      if (call_valid) begin
        if (!c_stall) begin
          c_stall = 1; c_seen = call_addr; call_ready = 1'b0;
        end else begin
          check(call_addr == c_seen, "R9", "call addr held", int'(call_addr), int'(c_seen));
          check(call_addr == v.exp_addr, (v.mode == 2'd1) ? "R6" : (v.mode == 2'd0) ? "R7" : "R5",
                "call addr", int'(call_addr), int'(v.exp_addr));
          check(call_exec == v.exp_exec, "R7", "call exec", int'(call_exec), int'(v.exp_exec));
          if (v.exp_exec) check(call_byte == v.vec, "R7", "call byte", int'(call_byte), int'(v.vec));
          call_ready = 1'b1; done = 1;
        end
      end else call_ready = 1'b0;
    end
    @(negedge clk);
    call_ready = 1'b0; dbus_valid = 1'b0; mem_rd_ready = 1'b0; int_n = 1'b1;
    check(done, "R2", "call completed", int'(done), 1);
    check(m1_alone, "R4", "lone m1 cycle seen", int'(m1_alone), 1);
    check(rd_n == ((v.mode[1]) ? 2 : 0), "R5", "table read count", rd_n, (v.mode[1]) ? 2 : 0);
    check(ie_o == 1'b0, "R3", "ie cleared", int'(ie_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    check(!ack_m1 && !ack_iorq && !call_valid && !mem_rd_valid && !ie_o, "R1",
          "outputs in reset", {ack_m1, ack_iorq, call_valid, mem_rd_valid, ie_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!ack_m1 && !call_valid && !ie_o, "R1", "outputs after reset",
          {ack_m1, call_valid, ie_o}, 0);

    // R2: flag clear, request ignored
    insn_end = 1'b1; int_n = 1'b0; seen = 0;
    repeat (20) begin @(negedge clk); if (ack_m1 || call_valid) seen++; end
    check(seen == 0, "R2", "no ack while disabled", seen, 0);
    int_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      pulse_ie();
      run_int(VECS[k]);
      repeat (3) @(negedge clk);
    end

    // R2: no boundary, request held off, then taken
    pulse_ie();
    insn_end = 1'b0; int_n = 1'b0; seen = 0;
    repeat (20) begin @(negedge clk); if (ack_m1) seen++; end
    check(seen == 0, "R2", "no ack without boundary", seen, 0);
    check(ie_o == 1'b1, "R2", "ie kept while held off", int'(ie_o), 1);
    run_int(VECS[0]);
    repeat (3) @(negedge clk);

    // R8: NMI beats pending INT, leaves ie alone
    pulse_ie();
    insn_end = 1'b0; int_n = 1'b0; nmi_n = 1'b0;
    repeat (5) @(negedge clk);
    insn_end = 1'b1; seen = 0;
    begin
      bit got = 0;
      for (int c = 0; c < 20 && !got; c++) begin
        @(negedge clk);
        if (ack_m1) seen++;
        if (call_valid) begin
          check(call_addr == 16'h0066, "R8", "nmi target", int'(call_addr), 16'h0066);
          check(call_exec == 1'b0, "R8", "nmi exec", int'(call_exec), 0);
          check(ie_o == 1'b1, "R8", "ie kept by nmi", int'(ie_o), 1);
          call_ready = 1'b1; got = 1;
        end
      end
      check(got, "R8", "nmi call issued", int'(got), 1);
    end
    check(seen == 0, "R8", "no ack before nmi call", seen, 0);
    run_int(VECS[1]);
    seen = 0;
    repeat (20) begin @(negedge clk); if (call_valid) seen++; end
    check(seen == 0, "R8", "held nmi no retrigger", seen, 0);
    nmi_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule